// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block derives every drive pulse that a linear CCD line sensor needs from one fast system clock. The sensor has 5150 effective pixels and a 63-pixel dummy lead-in. A line opens with a freeze phase: the two transfer phases are held static (phase A high, phase B low) while the readout gate pulses high for a programmed number of cycles. The block keeps set gaps both before and after that pulse. A transfer phase of `NPIX` pixel periods follows. In it, phase A is high for the first half of each period, phase B is its complement, and the last-stage clock copies phase A. The node-reset pulse and the clamp pulse each sit at a fixed offset within every period. An optional integration stretch of idle pixel periods can follow before the next gate.

Downstream capture logic receives a pixel index with a valid flag and a one-cycle line-start strobe. These are plain strobes and not a stream handshake. The sensor cannot be stalled, so the block has no ready input and takes no back-pressure. A consumer must accept one index per pixel period. All widths and gaps are parameters counted in system-clock cycles. The elaboration step rejects any setting that breaks the sensor's minimum timing at the stated clock period (`CLK_PS`). Software controls the block through a level enable and reads a busy flag.

Top module: `ccd_timing_gen`

## Requirements
- R1: After reset, and whenever idle, busy is low, phase A and the last-stage clock are low, phase B is high, and the gate, node-reset, clamp, valid and line-start outputs are low.
- R2: In the first cycle that line_en is seen high while idle, a line begins. Phase A is held high for T_SU cycles before the gate rises.
- R3: The gate stays high for exactly T_ROG cycles. Phase A stays high and unchanged for the whole of that time.
- R4: After the gate falls, phase A stays high for T_HD more cycles. Transfer then starts, and phase A first falls DIV/2 cycles into the first pixel period.
- R5: During transfer and integration, each pixel period is DIV cycles long. Phase A is high in cycles 0 to DIV/2-1 of the period. Phase B is always the inverse of phase A, and the last-stage clock always equals phase A.
- R6: In every pixel period, node-reset is high in cycles RS_OFS to RS_OFS+RS_W-1 and clamp is high in cycles CLP_OFS to CLP_OFS+CLP_W-1. The two are never high together.
- R7: During transfer, pix_valid is high and pix_idx counts 0 to NPIX-1, advancing once per pixel period. line_start is high only in the first cycle of index 0. pix_idx reads 0 whenever pix_valid is low.
- R8: The value of integ_len is captured as transfer starts. After the last transfer pixel, that many extra pixel periods follow with the clocks still running and pix_valid low. A value of 0 adds none.
- R9: If line_en is high in the last cycle of a line, the next line's freeze phase starts in the very next cycle. Otherwise the block goes idle. Dropping line_en part way through a line never shortens that line.
- R10: busy is high from the first freeze cycle through the last cycle of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | 1 | Level enable; lines repeat while it is high |
| integ_len | input | INTEG_W | Idle pixel periods after each transfer |
| gate_o | output | 1 | Readout-gate pulse |
| sh1_o | output | 1 | Transfer phase A |
| sh2_o | output | 1 | Transfer phase B (inverse of A) |
| shlast_o | output | 1 | Last-stage transfer clock (follows A) |
| noderst_o | output | 1 | Per-pixel node-reset pulse |
| clamp_o | output | 1 | Per-pixel clamp pulse |
| pix_idx | output | PIX_W | Pixel index within the transfer phase |
| pix_valid | output | 1 | High while transfer pixels are being output |
| line_start | output | 1 | One-cycle strobe at index 0 |
| busy | output | 1 | High while a line is in progress |

## Verification
Some properties are checked on every cycle. The gate is only ever high while phase A is frozen high. The gate width matches T_ROG exactly. The freeze gap before the gate and the gap from gate fall to the next phase-A fall are at least their minimums. Node-reset and clamp never overlap. The pixel index only steps by one, and line_start coincides with index 0. Nothing toggles while idle. Other behaviour shows only in the bench's scenarios. These are the exact cycle positions of each pulse within a line, the index reaching NPIX-1, the captured integration length with zero and nonzero values, back-to-back lines, and a stop that lets the running line finish.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GATE,
    ST_HOLD,
    ST_XFER,
    ST_INTEG
  } seq_st_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cbits(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen
  import ccd_tg_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int RS_OFS  = 0,
  parameter int RS_W    = 1,
  parameter int CLP_OFS = 2,
  parameter int CLP_W   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ph_first,
  output logic ph_wrap,
  output logic p1_run,
  output logic rs_win,
  output logic clp_win
);

  localparam int PW   = cbits(DIV);
  localparam int HALF = DIV / 2;
  localparam int WOFS [2] = '{RS_OFS, CLP_OFS};
  localparam int WLEN [2] = '{RS_W, CLP_W};

  logic [PW-1:0] ph;
  logic [1:0]    win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (!run || ph == PW'(DIV - 1)) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign ph_first = run && (ph == '0);
  assign ph_wrap  = run && (ph == PW'(DIV - 1));
  assign p1_run   = (int'(ph) < HALF);

  for (genvar gi = 0; gi < 2; gi++) begin : g_win
    assign win[gi] = run && (int'(ph) >= WOFS[gi]) && (int'(ph) < WOFS[gi] + WLEN[gi]);
  end

  assign rs_win  = win[0];
  assign clp_win = win[1];

endmodule

// File: rtl/ccd_line_fsm.sv
module ccd_line_fsm
  import ccd_tg_pkg::*;
#(
  parameter int NPIX    = 5220,
  parameter int T_SU    = 4,
  parameter int T_ROG   = 320,
  parameter int T_HD    = 128,
  parameter int INTEG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_en,
  input  logic [INTEG_W-1:0] integ_len,
  input  logic               ph_wrap,
  output seq_st_t            state,
  output logic [cbits(NPIX)-1:0] pix_cnt
);

  localparam int TW    = cbits(max3(T_SU, T_ROG, T_HD) + 1);
  localparam int PIX_W = cbits(NPIX);
  localparam int CNT_W = (PIX_W > INTEG_W) ? PIX_W : INTEG_W;

  logic [TW-1:0]      tcnt;
  logic [CNT_W-1:0]   pcnt;
  logic [INTEG_W-1:0] integ_q;
  seq_st_t            after_line;

  assign after_line = line_en ? ST_SETUP : ST_IDLE;
  assign pix_cnt    = pcnt[PIX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tcnt    <= '0;
      pcnt    <= '0;
      integ_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tcnt <= '0;
          pcnt <= '0;
          if (line_en) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (tcnt == TW'(T_SU - 1)) begin
            state <= ST_GATE;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_GATE: begin
          if (tcnt == TW'(T_ROG - 1)) begin
            state <= ST_HOLD;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (tcnt == TW'(T_HD - 1)) begin
            state   <= ST_XFER;
            tcnt    <= '0;
            pcnt    <= '0;
            integ_q <= integ_len;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (ph_wrap) begin
            if (pcnt == CNT_W'(NPIX - 1)) begin
              pcnt  <= '0;
              state <= (integ_q == '0) ? after_line : ST_INTEG;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        ST_INTEG: begin
          if (ph_wrap) begin
            if (pcnt == CNT_W'(integ_q) - 1'b1) begin
              pcnt  <= '0;
              state <= after_line;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int CLK_PS  = 15625,
  parameter int DIV     = 4,
  parameter int NPIX    = 5220,
  parameter int T_SU    = 4,
  parameter int T_ROG   = 320,
  parameter int T_HD    = 128,
  parameter int RS_OFS  = 0,
  parameter int RS_W    = 1,
  parameter int CLP_OFS = 2,
  parameter int CLP_W   = 1,
  parameter int INTEG_W = 8,
  localparam int PIX_W  = cbits(NPIX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_en,
  input  logic [INTEG_W-1:0] integ_len,
  output logic               gate_o,
  output logic               sh1_o,
  output logic               sh2_o,
  output logic               shlast_o,
  output logic               noderst_o,
  output logic               clamp_o,
  output logic [PIX_W-1:0]   pix_idx,
  output logic               pix_valid,
  output logic               line_start,
  output logic               busy
);

  if (NPIX < 5220) begin : g_bad_npix
    $error("line shorter than 5220 pixel periods");
  end
  if (DIV < 2 || DIV * CLK_PS < 62500) begin : g_bad_div
    $error("pixel rate above 16 MHz");
  end
  if (T_SU * CLK_PS < 50000) begin : g_bad_su
    $error("gate setup gap below 50 ns");
  end
  if (T_ROG * CLK_PS < 3000000) begin : g_bad_rog
    $error("gate pulse below 3 us");
  end
  if (T_HD * CLK_PS < 1000000) begin : g_bad_hd
    $error("gate hold gap below 1 us");
  end
  if (RS_W * CLK_PS < 10000 || RS_OFS + RS_W > CLP_OFS || CLP_OFS + CLP_W > DIV) begin : g_bad_pls
    $error("reset/clamp placement invalid");
  end

  seq_st_t          state;
  logic [PIX_W-1:0] pix_cnt;
  logic             run, freeze;
  logic             ph_first, ph_wrap, p1_run, rs_win, clp_win;

  assign run    = (state == ST_XFER) || (state == ST_INTEG);
  assign freeze = (state == ST_SETUP) || (state == ST_GATE) || (state == ST_HOLD);

  ccd_phase_gen #(
    .DIV(DIV), .RS_OFS(RS_OFS), .RS_W(RS_W), .CLP_OFS(CLP_OFS), .CLP_W(CLP_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ph_first(ph_first), .ph_wrap(ph_wrap), .p1_run(p1_run),
    .rs_win(rs_win), .clp_win(clp_win)
  );

  ccd_line_fsm #(
    .NPIX(NPIX), .T_SU(T_SU), .T_ROG(T_ROG), .T_HD(T_HD), .INTEG_W(INTEG_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .integ_len(integ_len),
    .ph_wrap(ph_wrap), .state(state), .pix_cnt(pix_cnt)
  );

  assign sh1_o      = freeze | (run & p1_run);
  assign sh2_o      = ~sh1_o;
  assign shlast_o   = sh1_o;
  assign gate_o     = (state == ST_GATE);
  assign noderst_o  = rs_win;
  assign clamp_o    = clp_win;
  assign pix_valid  = (state == ST_XFER);
  assign pix_idx    = pix_valid ? pix_cnt : '0;
  assign line_start = pix_valid && ph_first && (pix_cnt == '0);
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/ccd_timing_gen_chk.sv
module ccd_timing_gen_chk #(
  parameter int T_SU  = 4,
  parameter int T_ROG = 320,
  parameter int T_HD  = 128,
  parameter int PIX_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_o,
  input logic             sh1_o,
  input logic             noderst_o,
  input logic             clamp_o,
  input logic [PIX_W-1:0] pix_idx,
  input logic             pix_valid,
  input logic             line_start,
  input logic             busy
);

  logic [19:0] gate_len, sh1_age, since_gate;
  logic        sh1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_len   <= '0;
      sh1_age    <= '0;
      since_gate <= '0;
      sh1_q      <= 1'b0;
    end else begin
      sh1_q      <= sh1_o;
      gate_len   <= gate_o ? gate_len + 1'b1 : '0;
      sh1_age    <= (sh1_o != sh1_q) ? '0 : ((&sh1_age) ? sh1_age : sh1_age + 1'b1);
      since_gate <= gate_o ? '0 : ((&since_gate) ? since_gate : since_gate + 1'b1);
    end
  end

  // R3
  gate_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> (sh1_o && $stable(sh1_o)));

  // R3
  gate_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> (gate_len == 20'(T_ROG)));

  // R2
  gate_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (sh1_age >= 20'(T_SU - 1)));

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh1_o) |-> (since_gate >= 20'(T_HD)));

  // R6
  pulse_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(noderst_o && clamp_o));

  // R7
  start_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (pix_valid && pix_idx == '0));

  // R7
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid) && pix_idx != $past(pix_idx))
      |-> (pix_idx == $past(pix_idx) + 1'b1));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!gate_o && !pix_valid && !noderst_o && !clamp_o && !sh1_o));

endmodule

bind ccd_timing_gen ccd_timing_gen_chk #(
  .T_SU(T_SU), .T_ROG(T_ROG), .T_HD(T_HD), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_o(gate_o), .sh1_o(sh1_o),
  .noderst_o(noderst_o), .clamp_o(clamp_o), .pix_idx(pix_idx),
  .pix_valid(pix_valid), .line_start(line_start), .busy(busy)
);

// File: tb/ccd_timing_gen_test.sv
module ccd_timing_gen_test;

  localparam int CLK_PERIOD = 16;
  localparam int NROW = 18;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_en = 1'b0;
  logic [7:0]  integ_len = 8'd0;
  logic        gate_o, sh1_o, sh2_o, shlast_o, noderst_o, clamp_o;
  logic [12:0] pix_idx;
  logic        pix_valid, line_start, busy;

  int n_chk = 0;
  int n_bad = 0;
  int k = 0;
  int ls_seen = 0;
  int cyc = 0;
  bit done = 1'b0;

  ccd_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .integ_len(integ_len),
    .gate_o(gate_o), .sh1_o(sh1_o), .sh2_o(sh2_o), .shlast_o(shlast_o),
    .noderst_o(noderst_o), .clamp_o(clamp_o), .pix_idx(pix_idx),
    .pix_valid(pix_valid), .line_start(line_start), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // row: {k, idx, gate, sh1, rs, clp, valid, ls, busy}
  function automatic logic [54:0] mk(input int kk, input int idx, input logic [6:0] f);
    return {kk[31:0], idx[15:0], f};
  endfunction

  localparam logic [54:0] VEC [NROW] = '{
    mk(0,     0,    7'b0100001),  // R2 freeze begins
    mk(3,     0,    7'b0100001),  // R2
    mk(4,     0,    7'b1100001),  // R3 gate rises
    mk(323,   0,    7'b1100001),  // R3 last gate cycle
    mk(324,   0,    7'b0100001),  // R4 hold
    mk(451,   0,    7'b0100001),  // R4 last hold cycle
    mk(452,   0,    7'b0110111),  // R6 R7 first pixel, start strobe
    mk(453,   0,    7'b0100101),  // R5
    mk(454,   0,    7'b0001101),  // R5 R6 clamp
    mk(455,   0,    7'b0000101),  // R5
    mk(456,   1,    7'b0110101),  // R7 index 1
    mk(459,   1,    7'b0000101),  // R5
    mk(21330, 5219, 7'b0001101),  // R7 last index
    mk(21332, 0,    7'b0110001),  // R8 integration, clocks on
    mk(21334, 0,    7'b0001001),  // R8
    mk(21339, 0,    7'b0000001),  // R8 last idle period cycle
    mk(21340, 0,    7'b0100001),  // R9 back-to-back freeze
    mk(21344, 0,    7'b1100001)   // R9 R3 second gate
  };

  task automatic goto(input int target);
    while (k < target) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at k=%0d: actual %0h expected %0h", req, k, act, exp);
    end
  endtask

  function automatic logic [22:0] snap();
    return {3'b0, pix_idx, gate_o, sh1_o, noderst_o, clamp_o, pix_valid, line_start, busy};
  endfunction

  always @(negedge clk) begin
    if (line_start) ls_seen++;
    cyc++;
    if (!done && cyc > LIMIT) begin
      done = 1'b1;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {26'b0, gate_o, sh1_o, sh2_o, noderst_o, clamp_o, busy}, 32'b001000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", {27'b0, sh1_o, shlast_o, sh2_o, pix_valid, busy}, 32'b00100);

    integ_len = 8'd2;
    line_en   = 1'b1;
    k = -1;
    for (int r = 0; r < NROW; r++) begin
      goto(int'(VEC[r][54:23]));
      chk("R2-R9 table", 32'(snap()), 32'({VEC[r][22:7], VEC[r][6:0]}));
      // R5 phase B and last-stage relation
      chk("R5", {30'b0, sh2_o, shlast_o}, {30'b0, ~sh1_o, sh1_o});
      if (r == NROW - 1) begin
        line_en   = 1'b0;  // R9 stop mid-line
      end
    end

    goto(21400);
    integ_len = 8'd0;  // R8 zero captured for line 2
    goto(21792);
    chk("R7 R9 second line start", {29'b0, line_start, pix_valid, busy}, 32'b111);
    goto(42671);
    chk("R10 last cycle busy", {18'b0, pix_idx, sh1_o, busy}, {18'b0, 13'd5219, 1'b0, 1'b1});
    goto(42672);
    chk("R8 R9 R10 idle after zero integration", {28'b0, busy, pix_valid, sh1_o, sh2_o}, 32'b0001);
    goto(42700);
    chk("R1 R9 stays idle", {29'b0, busy, gate_o, noderst_o}, 32'b000);
    chk("R7 one strobe per line", 32'(ls_seen), 32'd2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule